// File: doc/BRIEF.md
# Binary to Two-Digit Decimal Display

This block takes a 4-bit unsigned binary value and shows it as two decimal digits on a pair of 7-segment displays: a tens digit that can only be 0 or 1, and a units digit from 0 to 9. It is purely combinational. A magnitude comparator raises a flag when the input is above nine. Per-bit 2:1 multiplexers, steered by that flag, choose between the raw input and a corrected code equal to the input minus ten.

The chosen 4-bit units code and the comparator flag are outputs of the block. The tens display is driven from the flag alone. A BCD-to-7-segment decoder, built from flat Boolean equations, drives the units display. Every function is a continuous assignment with no procedural branching, so each output is a fixed sum-of-products of the four input bits.

Segment outputs are active-low, so a 0 lights a segment. In each 7-bit segment bus, bit 0 is the top bar (a), and bits 1 to 6 are b, c, d, e, f and g in clockwise order, with bit 6 as the middle bar (g).

Top module: `bin2dec_display`

## Requirements
- R1: `over_nine` is 1 exactly when `bin_in` is 10 to 15, and 0 for 0 to 9.
- R2: For `bin_in` from 0 to 9, `units_code` equals `bin_in`.
- R3: For `bin_in` from 10 to 15, `units_code` equals `bin_in` minus ten, so it rises from 0 to 5 in input order.
- R4: `units_code` never exceeds 9 for any input.
- R5: `tens_seg_n` is 7'b1000000 (digit 0: every segment lit except g) when `over_nine` is 0, and 7'b1111001 (digit 1: only b and c lit) when `over_nine` is 1.
- R6: `units_seg_n` shows the decimal digit `units_code` with active-low standard patterns. With bit 0 = a: 0=7'h40, 1=7'h79, 2=7'h24, 3=7'h30, 4=7'h19, 5=7'h12, 6=7'h02, 7=7'h78, 8=7'h00, 9=7'h10.
- R7: The block is combinational. Every output settles to its new value within the same clock period in which `bin_in` changes, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bin_in | input | 4 | Unsigned binary value to display |
| over_nine | output | 1 | High when the input is above nine |
| units_code | output | 4 | BCD code of the units digit |
| tens_seg_n | output | 7 | Active-low segments of the tens display (bit 0 = a, bit 6 = g) |
| units_seg_n | output | 7 | Active-low segments of the units display (bit 0 = a, bit 6 = g) |

## Verification
The bench walks all sixteen input codes in ascending order. It then applies a descending sweep and a scattered order that switches between the two ranges at every step.

The ascending sweep shows that the comparator boundary sits between 9 and 10 and not one code away. The descending and alternating orders show that each output depends only on the present input, with no memory of the previous one.

At every step the tens and units segment patterns are compared against digits computed by integer division and remainder. This tells a wrong correction bit apart from a wrong segment equation.

// File: rtl/b2d_pkg.sv
// Package: shared widths and types for the binary-to-decimal display.
// Assumes a single 4-bit input and 7-segment displays with bit 0 = segment a.
package b2d_pkg;
    localparam int BIN_W   = 4;
    localparam int SEG_W   = 7;
    localparam int DEC_MAX = 9;

    typedef logic [BIN_W-1:0] nib_t;
    typedef logic [SEG_W-1:0] seg_t;
endpackage

// File: rtl/b2d_compare.sv
// Module: magnitude comparator that flags inputs above nine.
// Assumes a 4-bit unsigned input. A value exceeds nine only when the top
// bit is set and at least one of the two middle bits is set.
module b2d_compare
    import b2d_pkg::*;
(
    input  nib_t value_i,
    output logic above_o
);
    // Flag values 10..15 as a single product-of-sums term.
    assign above_o = value_i[3] & (value_i[2] | value_i[1]);
endmodule

// File: rtl/b2d_correct.sv
// Module: subtract-ten correction for inputs in 10..15.
// Assumes the result is used only when the comparator flag is set; for
// inputs 0..9 the outputs are don't-cares and are discarded by the mux.
module b2d_correct
    import b2d_pkg::*;
(
    input  nib_t value_i,
    output nib_t minus10_o
);
    // Bit 3 of the result is always clear in range 0..5.
    assign minus10_o[3] = 1'b0;
    // Bit 2 set for results 4 and 5 (inputs 14, 15).
    assign minus10_o[2] = value_i[2] & value_i[1];
    // Bit 1 set for results 2 and 3 (inputs 12, 13).
    assign minus10_o[1] = value_i[2] & ~value_i[1];
    // Bit 0 follows the input parity, since ten is even.
    assign minus10_o[0] = value_i[0];
endmodule

// File: rtl/b2d_mux.sv
// Module: per-bit 2:1 selector between raw and corrected units code.
// Assumes equal widths on both data inputs; one select for all bits.
module b2d_mux
    import b2d_pkg::*;
#(
    parameter int WIDTH = BIN_W
)(
    input  logic [WIDTH-1:0] raw_i,
    input  logic [WIDTH-1:0] fix_i,
    input  logic             sel_i,
    output logic [WIDTH-1:0] out_o
);
    // One Boolean 2:1 selector per bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign out_o[i] = (~sel_i & raw_i[i]) | (sel_i & fix_i[i]);
    end
endmodule

// File: rtl/b2d_tens.sv
// Module: tens-digit driver showing 0 or 1 from the comparator flag.
// Assumes active-low segments, bit 0 = a through bit 6 = g.
module b2d_tens
    import b2d_pkg::*;
(
    input  logic one_i,
    output seg_t seg_n_o
);
    // Segments a, d, e, f go dark for digit 1; b, c always lit; g always dark.
    assign seg_n_o[0] = one_i;
    assign seg_n_o[1] = 1'b0;
    assign seg_n_o[2] = 1'b0;
    assign seg_n_o[3] = one_i;
    assign seg_n_o[4] = one_i;
    assign seg_n_o[5] = one_i;
    assign seg_n_o[6] = 1'b1;
endmodule

// File: rtl/b2d_segdec.sv
// Module: BCD to 7-segment decoder as flat sum-of-products equations.
// Assumes codes 10..15 never occur (treated as don't-cares when minimising).
// Outputs are active-low, bit 0 = a through bit 6 = g.
module b2d_segdec
    import b2d_pkg::*;
(
    input  nib_t code_i,
    output seg_t seg_n_o
);
    logic b3, b2, b1, b0;
    seg_t lit;

    // Name the code bits for readability of the equations.
    assign b3 = code_i[3];
    assign b2 = code_i[2];
    assign b1 = code_i[1];
    assign b0 = code_i[0];

    // Active-high segment-on terms, one per segment.
    assign lit[0] = b3 | b1 | (b2 & b0) | (~b2 & ~b0);
    assign lit[1] = ~b2 | (~b1 & ~b0) | (b1 & b0);
    assign lit[2] = b2 | ~b1 | b0;
    assign lit[3] = b3 | (~b2 & ~b0) | (b1 & ~b0) | (~b2 & b1) | (b2 & ~b1 & b0);
    assign lit[4] = (~b2 & ~b0) | (b1 & ~b0);
    assign lit[5] = b3 | (~b1 & ~b0) | (b2 & ~b1) | (b2 & ~b0);
    assign lit[6] = b3 | (b2 & ~b1) | (~b2 & b1) | (b1 & ~b0);

    // Invert for the active-low display.
    assign seg_n_o = ~lit;
endmodule

// File: rtl/bin2dec_display.sv
// Module: top of the binary to two-digit decimal display.
// Wires the comparator, correction, selector, tens driver and units decoder.
// Purely combinational; assumes no clock and no reset.
module bin2dec_display
    import b2d_pkg::*;
(
    input  logic [3:0] bin_in,
    output logic       over_nine,
    output logic [3:0] units_code,
    output logic [6:0] tens_seg_n,
    output logic [6:0] units_seg_n
);
    nib_t minus10;

    b2d_compare u_cmp (
        .value_i (bin_in),
        .above_o (over_nine)
    );

    b2d_correct u_fix (
        .value_i   (bin_in),
        .minus10_o (minus10)
    );

    b2d_mux #(.WIDTH(BIN_W)) u_mux (
        .raw_i (bin_in),
        .fix_i (minus10),
        .sel_i (over_nine),
        .out_o (units_code)
    );

    b2d_tens u_tens (
        .one_i   (over_nine),
        .seg_n_o (tens_seg_n)
    );

    b2d_segdec u_units (
        .code_i  (units_code),
        .seg_n_o (units_seg_n)
    );
endmodule

// File: rtl/bin2dec_display_chk.sv
// Module: checker for the display top, attached by bind.
// Uses immediate assertions because the block has no clock.
module bin2dec_display_chk (
    input logic [3:0] bin_in,
    input logic       over_nine,
    input logic [3:0] units_code,
    input logic [6:0] tens_seg_n
);
    // Relate ports of the top combinationally.
    always_comb begin
        assert_flag_R1: assert (over_nine == (bin_in > 4'd9))
            else $error("flag wrong for %0d", bin_in);
        assert_low_pass_R2: assert (over_nine || units_code == bin_in)
            else $error("units wrong for %0d", bin_in);
        assert_high_fix_R3: assert (!over_nine || units_code + 4'd10 == bin_in)
            else $error("units wrong for %0d", bin_in);
        assert_bcd_range_R4: assert (units_code <= 4'd9)
            else $error("units out of range %0d", units_code);
        assert_tens_pat_R5: assert (tens_seg_n == (over_nine ? 7'b1111001 : 7'b1000000))
            else $error("tens pattern wrong");
    end
endmodule

bind bin2dec_display bin2dec_display_chk u_chk (
    .bin_in     (bin_in),
    .over_nine  (over_nine),
    .units_code (units_code),
    .tens_seg_n (tens_seg_n)
);

// File: tb/sim_bin2dec_display.sv
// Bench: drives input sequences each clock and compares every output
// against digits computed by division and remainder.
module sim_bin2dec_display;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bin_in = 4'd0;
    logic       over_nine;
    logic [3:0] units_code;
    logic [6:0] tens_seg_n;
    logic [6:0] units_seg_n;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit finished = 1'b0;
    int seq[$];

    bin2dec_display u0 (
        .bin_in      (bin_in),
        .over_nine   (over_nine),
        .units_code  (units_code),
        .tens_seg_n  (tens_seg_n),
        .units_seg_n (units_seg_n)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    // Active-low pattern for a decimal digit, bit 0 = a.
    function automatic logic [6:0] seg_of(input int d);
        logic [6:0] on;
        case (d)
            0: on = 7'b0111111;
            1: on = 7'b0000110;
            2: on = 7'b1011011;
            3: on = 7'b1001111;
            4: on = 7'b1100110;
            5: on = 7'b1101101;
            6: on = 7'b1111101;
            7: on = 7'b0000111;
            8: on = 7'b1111111;
            9: on = 7'b1101111;
            default: on = 7'b0000000;
        endcase
        return ~on;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s input=%0d actual=%0h expected=%0h", req, bin_in, act, exp);
        end
    endtask

    // Compare all outputs against the reference digits for the present input.
    task automatic check_all();
        int v, tens, ones;
        v = int'(bin_in);
        tens = v / 10;
        ones = v % 10;
        chk(over_nine == (tens == 1), "R1", int'(over_nine), tens);
        if (v <= 9) chk(int'(units_code) == v, "R2", int'(units_code), v);
        else        chk(int'(units_code) == ones, "R3", int'(units_code), ones);
        chk(units_code <= 4'd9, "R4", int'(units_code), 9);
        chk(tens_seg_n == seg_of(tens), "R5", int'(tens_seg_n), int'(seg_of(tens)));
        chk(units_seg_n == seg_of(ones), "R6", int'(units_seg_n), int'(seg_of(ones)));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // Ascending sweep, then descending, then alternating ranges.
        for (int i = 0; i < 16; i++) seq.push_back(i);
        for (int i = 15; i >= 0; i--) seq.push_back(i);
        seq.push_back(9);  seq.push_back(10); seq.push_back(3);
        seq.push_back(15); seq.push_back(0);  seq.push_back(12);
        seq.push_back(7);  seq.push_back(11); seq.push_back(8);
        seq.push_back(14);

        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Initial state with input zero shows 0 and 0.
        @(negedge clk);
        check_all();

        foreach (seq[k]) begin
            @(posedge clk);
            #1 bin_in = 4'(seq[k]);
            // R7: outputs must already hold the new value half a period later.
            @(negedge clk);
            check_all();
        end

        // R7: a change between edges is visible before the next edge.
        @(posedge clk);
        #1 bin_in = 4'd13;
        #2;
        chk(units_code == 4'd3 && over_nine, "R7", int'(units_code), 3);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule